// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block decides, for every received CAN frame, whether the frame is kept and which of two receive queues it goes to. The decision uses an array of configurable filter banks, 14 by default. Each bank holds two 32-bit words. Per-bank control bits set four things: whether the bank is an exact-identifier list or an identifier/mask pair, whether it compares at full 32-bit width or as two 16-bit halves, whether it is active, and which queue its matches go to.

Software configures the array through a simple write port. It first raises a global configuration flag, deactivates a bank before rewriting that bank's words, and then clears the flag to resume filtering. The receiver presents an identifier word with a one-cycle valid strobe. One clock later the block returns a result strobe with an accept flag and a queue select. When several active banks match, the bank with the lowest number sets the queue.

Top module: `canAcceptFilter`

## Requirements
- R1: After reset the configuration flag is set, all banks are inactive, every bank word and control vector is zero, and `hitValid`, `hitAccept` and `hitQueue` are low.
- R2: A frame presented with `frmValid` high at a rising edge produces `hitValid` high for exactly one cycle, after that edge. `hitValid` is low in every other cycle, and `hitAccept` is never high without `hitValid`.
- R3: While the configuration flag (bit 0 of address 0, writable at any time) is set, every frame is rejected.
- R4: A bank in list mode at 32-bit scale accepts an identifier equal to either of its two words.
- R5: A bank in mask mode at 32-bit scale treats word A as the identifier and word B as the mask. It accepts when `(id ^ A) & B` is zero. For example, A=0x102 with B=0x7FE accepts 0x102 and 0x103, and A=0x102 with B=0x7FF rejects 0x103.
- R6: At 16-bit scale, only bits 15:0 of the identifier word are compared. In list mode, the key is accepted if it equals any of the four 16-bit halves of the bank's words.
- R7: In mask mode at 16-bit scale, the lower halves of A and B form one identifier/mask pair and the upper halves form a second pair. The bank matches if either pair matches.
- R8: Inactive banks never match. A frame that matches no active bank is rejected, and a rejected result carries `hitQueue` = 0.
- R9: An accepted frame's `hitQueue` equals the queue bit of the deciding bank (0 = queue 0, 1 = queue 1).
- R10: When several active banks match, the lowest-numbered one decides the queue.
- R11: Writes to the control vectors are ignored while the configuration flag is clear. Bit b of each vector applies to bank b. The vectors are: list mode (address 1, 1 = list), 32-bit scale (address 2, 1 = 32-bit), queue (address 3), active (address 4).
- R12: Bank b's word A is at address 32+2b and word B at 33+2b. A write to either word is ignored unless the configuration flag is set and bank b is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | AddrW (6) | Configuration word address |
| cfgWdata | input | 32 | Configuration write data |
| frmValid | input | 1 | Frame identifier present this cycle |
| frmId | input | 32 | Frame identifier word |
| hitValid | output | 1 | Filter result strobe |
| hitAccept | output | 1 | Frame accepted |
| hitQueue | output | 1 | Receive queue for an accepted frame |

## Verification
The assertions assume that `frmValid` and the configuration port are driven only while reset is released. They also assume that the configuration flag and the active vector change only through the write port, so stability after a locked write depends on the port alone. The stimulus applies inputs at the falling clock edge. It issues single-cycle writes and single-cycle frames with at least one idle cycle between them, so every result strobe can be attributed to exactly one frame. All reconfiguration of a bank's words follows the documented order: flag set, bank deactivated, words written, bank reactivated, flag cleared.

// File: rtl/canfPkg.sv
package canfPkg;
  localparam int DataW    = 32;
  localparam int HalfW    = DataW / 2;
  localparam int BankSelW = 4;

  // strobes from the write decoder to the filter datapath
  typedef struct packed {
    logic                wrInit;
    logic                wrMode;
    logic                wrScale;
    logic                wrQueue;
    logic                wrActive;
    logic                wrRegA;
    logic                wrRegB;
    logic [BankSelW-1:0] bank;
    logic [DataW-1:0]    data;
  } cfgStrobe_t;
endpackage

// File: rtl/canfBank.sv
module canfBank
  import canfPkg::*;
(
  input  logic [DataW-1:0] regA,
  input  logic [DataW-1:0] regB,
  input  logic             listMode,
  input  logic             wide,
  input  logic [DataW-1:0] key,
  output logic             hit
);
  logic [HalfW-1:0] key16;
  logic [HalfW-1:0] aLo, aHi, bLo, bHi;
  logic             hitList32, hitMask32, hitList16, hitMask16;

  assign key16 = key[HalfW-1:0];
  assign aLo   = regA[HalfW-1:0];
  assign aHi   = regA[DataW-1:HalfW];
  assign bLo   = regB[HalfW-1:0];
  assign bHi   = regB[DataW-1:HalfW];

  assign hitList32 = (key == regA) || (key == regB);
  assign hitMask32 = ((key ^ regA) & regB) == '0;
  assign hitList16 = (key16 == aLo) || (key16 == aHi) ||
                     (key16 == bLo) || (key16 == bHi);
  assign hitMask16 = (((key16 ^ aLo) & bLo) == '0) ||
                     (((key16 ^ aHi) & bHi) == '0);

  always_comb begin
    unique case ({listMode, wide})
      2'b11:   hit = hitList32;
      2'b01:   hit = hitMask32;
      2'b10:   hit = hitList16;
      default: hit = hitMask16;
    endcase
  end
endmodule

// File: rtl/canfCtrl.sv
module canfCtrl
  import canfPkg::*;
#(
  parameter int NumBanks = 14,
  parameter int AddrW    = 6
) (
  input  logic                cfgWe,
  input  logic [AddrW-1:0]    cfgAddr,
  input  logic [DataW-1:0]    cfgWdata,
  input  logic                initBit,
  input  logic [NumBanks-1:0] activeVec,
  output cfgStrobe_t          stb
);
  localparam int OffW = AddrW - 1;

  logic                isBank;
  logic [OffW-1:0]     offs;
  logic [BankSelW-1:0] bankIdx;
  logic                inRange, bankBusy, ctlWe, bankWe;

  assign isBank   = cfgAddr[AddrW-1];
  assign offs     = cfgAddr[OffW-1:0];
  assign bankIdx  = BankSelW'(offs >> 1);
  assign inRange  = int'(bankIdx) < NumBanks;
  assign bankBusy = |(activeVec & (NumBanks'(1) << bankIdx));
  assign ctlWe    = cfgWe && !isBank && initBit;
  assign bankWe   = cfgWe && isBank && initBit && inRange && !bankBusy;

  always_comb begin
    stb          = '0;
    stb.wrInit   = cfgWe && !isBank && (offs == OffW'(0));
    stb.wrMode   = ctlWe && (offs == OffW'(1));
    stb.wrScale  = ctlWe && (offs == OffW'(2));
    stb.wrQueue  = ctlWe && (offs == OffW'(3));
    stb.wrActive = ctlWe && (offs == OffW'(4));
    stb.wrRegA   = bankWe && !offs[0];
    stb.wrRegB   = bankWe && offs[0];
    stb.bank     = bankIdx;
    stb.data     = cfgWdata;
  end
endmodule

// File: rtl/canfData.sv
module canfData
  import canfPkg::*;
#(
  parameter int NumBanks = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          stb,
  input  logic                frmValid,
  input  logic [DataW-1:0]    frmId,
  output logic                initBit,
  output logic [NumBanks-1:0] activeVec,
  output logic                hitValid,
  output logic                hitAccept,
  output logic                hitQueue
);
  logic [DataW-1:0]    regA [NumBanks];
  logic [DataW-1:0]    regB [NumBanks];
  logic [NumBanks-1:0] modeVec, scaleVec, queueVec;
  logic [NumBanks-1:0] rawHit, liveHit;
  logic                winQueue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initBit   <= 1'b1;
      modeVec   <= '0;
      scaleVec  <= '0;
      queueVec  <= '0;
      activeVec <= '0;
    end else begin
      if (stb.wrInit)   initBit   <= stb.data[0];
      if (stb.wrMode)   modeVec   <= stb.data[NumBanks-1:0];
      if (stb.wrScale)  scaleVec  <= stb.data[NumBanks-1:0];
      if (stb.wrQueue)  queueVec  <= stb.data[NumBanks-1:0];
      if (stb.wrActive) activeVec <= stb.data[NumBanks-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NumBanks; b++) begin
        regA[b] <= '0;
        regB[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NumBanks; b++) begin
        if (stb.wrRegA && (int'(stb.bank) == b)) regA[b] <= stb.data;
        if (stb.wrRegB && (int'(stb.bank) == b)) regB[b] <= stb.data;
      end
    end
  end

  for (genvar g = 0; g < NumBanks; g++) begin : gBank
    canfBank u_bank (
      .regA     (regA[g]),
      .regB     (regB[g]),
      .listMode (modeVec[g]),
      .wide     (scaleVec[g]),
      .key      (frmId),
      .hit      (rawHit[g])
    );
  end

  assign liveHit = rawHit & activeVec;

  // walk from the top down so the lowest matching bank is the last assignment
  always_comb begin
    winQueue = 1'b0;
    for (int b = NumBanks - 1; b >= 0; b--) begin
      if (liveHit[b]) winQueue = queueVec[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid  <= 1'b0;
      hitAccept <= 1'b0;
      hitQueue  <= 1'b0;
    end else begin
      hitValid  <= frmValid;
      hitAccept <= frmValid && !initBit && (|liveHit);
      hitQueue  <= frmValid && !initBit && (|liveHit) && winQueue;
    end
  end
endmodule

// File: rtl/canAcceptFilter.sv
module canAcceptFilter
  import canfPkg::*;
#(
  parameter int NumBanks = 14,
  parameter int AddrW    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [AddrW-1:0] cfgAddr,
  input  logic [31:0]      cfgWdata,
  input  logic             frmValid,
  input  logic [31:0]      frmId,
  output logic             hitValid,
  output logic             hitAccept,
  output logic             hitQueue
);
  cfgStrobe_t          stb;
  logic                initBit;
  logic [NumBanks-1:0] activeVec;

  canfCtrl #(.NumBanks(NumBanks), .AddrW(AddrW)) u_ctrl (
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .initBit   (initBit),
    .activeVec (activeVec),
    .stb       (stb)
  );

  canfData #(.NumBanks(NumBanks)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .frmValid  (frmValid),
    .frmId     (frmId),
    .initBit   (initBit),
    .activeVec (activeVec),
    .hitValid  (hitValid),
    .hitAccept (hitAccept),
    .hitQueue  (hitQueue)
  );
endmodule

// File: rtl/canfChecker.sv
module canfChecker #(
  parameter int NumBanks = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                frmValid,
  input logic                hitValid,
  input logic                hitAccept,
  input logic                hitQueue,
  input logic                initBit,
  input logic [NumBanks-1:0] activeVec
);
  p_result_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> hitValid);
  p_result_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frmValid |=> !hitValid);
  p_accept_in_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    hitAccept |-> hitValid);
  p_init_rejects_r3: assert property (@(posedge clk) disable iff (!rstN)
    (initBit && frmValid) |=> !hitAccept);
  p_reject_queue_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !hitAccept |-> !hitQueue);
  p_locked_active_r11: assert property (@(posedge clk) disable iff (!rstN)
    !initBit |=> $stable(activeVec));
endmodule

bind canAcceptFilter canfChecker #(.NumBanks(NumBanks)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frmValid  (frmValid),
  .hitValid  (hitValid),
  .hitAccept (hitAccept),
  .hitQueue  (hitQueue),
  .initBit   (initBit),
  .activeVec (activeVec)
);

// File: tb/sim_canAcceptFilter.sv
module sim_canAcceptFilter;
  localparam int NumBanks = 14;
  localparam int AddrW    = 6;
  localparam int NV       = 17;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [AddrW-1:0] cfgAddr = '0;
  logic [31:0]      cfgWdata = '0;
  logic             frmValid = 1'b0;
  logic [31:0]      frmId = '0;
  logic             hitValid, hitAccept, hitQueue;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  canAcceptFilter #(.NumBanks(NumBanks), .AddrW(AddrW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .frmValid(frmValid), .frmId(frmId),
    .hitValid(hitValid), .hitAccept(hitAccept), .hitQueue(hitQueue)
  );

  // {identifier, expected accept, expected queue}
  localparam logic [33:0] vecTab [NV] = '{
    {32'h0000_0102, 1'b1, 1'b0},  // R5 R10: bank0 beats bank4
    {32'h0000_0103, 1'b1, 1'b0},  // R5 low bit masked off
    {32'h0000_0104, 1'b0, 1'b0},  // R5 mismatch
    {32'h0000_0200, 1'b1, 1'b1},  // R4 R9 word A
    {32'h0000_0300, 1'b1, 1'b1},  // R4 word B
    {32'h0000_0201, 1'b0, 1'b0},  // R4 near miss
    {32'h0000_1111, 1'b1, 1'b0},  // R6 half 0
    {32'h0000_3333, 1'b1, 1'b0},  // R6 half 2
    {32'h0000_4444, 1'b1, 1'b0},  // R6 half 3
    {32'hABCD_1111, 1'b1, 1'b0},  // R6 upper bits ignored
    {32'h0000_1112, 1'b0, 1'b0},  // R6 miss
    {32'h0000_12F0, 1'b1, 1'b1},  // R7 lower pair
    {32'h0000_5A77, 1'b1, 1'b1},  // R7 upper pair
    {32'h0000_5B77, 1'b0, 1'b0},  // R7 miss
    {32'h0000_0777, 1'b0, 1'b0},  // R8 inactive bank5
    {32'h0000_2222, 1'b1, 1'b0},  // R6 half 1
    {32'h0000_FFFF, 1'b0, 1'b0}   // R8 no bank
  };
  localparam string vecTag [NV] = '{
    "R10", "R5", "R5", "R9", "R4", "R4", "R6", "R6", "R6", "R6", "R6",
    "R7", "R7", "R7", "R8", "R6", "R8"
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = AddrW'(addr); cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendFrame(input logic [31:0] id, input logic expAcc,
                           input logic expQ, input string tag);
    @(negedge clk);
    frmValid = 1'b1; frmId = id;
    @(negedge clk);
    frmValid = 1'b0;
    check({tag, " valid"}, 32'(hitValid), 32'd1);
    check({tag, " accept"}, 32'(hitAccept), 32'(expAcc));
    check({tag, " queue"}, 32'(hitQueue), 32'(expQ));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(hitValid), 0);
    check("R1 accept", 32'(hitAccept), 0);
    check("R1 queue", 32'(hitQueue), 0);
    rstN = 1'b1;
    // R1 R3: flag set after reset, frames rejected
    sendFrame(32'h0, 1'b0, 1'b0, "R1 init");

    cfgWrite(32, 32'h102); cfgWrite(33, 32'h7FE);  // bank0 mask32 q0
    cfgWrite(34, 32'h200); cfgWrite(35, 32'h300);  // bank1 list32 q1
    cfgWrite(36, 32'h2222_1111); cfgWrite(37, 32'h4444_3333); // bank2 list16
    cfgWrite(38, 32'h5A00_00F0); cfgWrite(39, 32'hFF00_00FF); // bank3 mask16 q1
    cfgWrite(40, 32'h102); cfgWrite(41, 32'h7FF);  // bank4 mask32 q1
    cfgWrite(42, 32'h777); cfgWrite(43, 32'h777);  // bank5 list32 inactive
    cfgWrite(1, 32'h26);
    cfgWrite(2, 32'h33);
    cfgWrite(3, 32'h3A);
    cfgWrite(4, 32'h1F);
    sendFrame(32'h102, 1'b0, 1'b0, "R3 flag set");
    cfgWrite(0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      sendFrame(vecTab[i][33:2], vecTab[i][1], vecTab[i][0], vecTag[i]);
    end

    // R2: no strobe in an idle cycle
    @(negedge clk);
    check("R2 idle", 32'(hitValid), 0);

    // R11: locked control writes ignored
    cfgWrite(4, 32'h0);
    sendFrame(32'h102, 1'b1, 1'b0, "R11 active locked");
    cfgWrite(3, 32'h0);
    sendFrame(32'h200, 1'b1, 1'b1, "R11 queue locked");
    // R12: word write with flag clear ignored
    cfgWrite(32, 32'h555);
    cfgWrite(0, 32'h1);
    // R12: word write into an active bank ignored
    cfgWrite(33, 32'h7FF);
    cfgWrite(0, 32'h0);
    sendFrame(32'h103, 1'b1, 1'b0, "R12 active bank");
    sendFrame(32'h555, 1'b0, 1'b0, "R12 flag clear");

    // proper sequence: deactivate, rewrite, reactivate
    cfgWrite(0, 32'h1);
    cfgWrite(4, 32'h1E);
    cfgWrite(33, 32'h7FF);
    cfgWrite(4, 32'h1F);
    cfgWrite(0, 32'h0);
    sendFrame(32'h103, 1'b0, 1'b0, "R5 strict mask");
    sendFrame(32'h102, 1'b1, 1'b0, "R10 lowest bank");
    // R10: with bank0 inactive, bank4 decides
    cfgWrite(0, 32'h1);
    cfgWrite(4, 32'h1E);
    cfgWrite(0, 32'h0);
    sendFrame(32'h102, 1'b1, 1'b1, "R10 next bank");

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule